// File: doc/BRIEF.md
# Standby Controller with Oscillator Stabilization Counter

This block sequences a small processor through two low-power states. In the light sleep state, only the CPU clock gate closes and the main oscillator keeps running. In the deep sleep state, the main oscillator enable also drops. The block watches a vector of interrupt request flags together with their mask flags. Any request that is not masked ends either sleep state.

Leaving deep sleep does not reopen the CPU clock at once. First the block counts a programmable settling interval of oscillator cycles. The interval is chosen through a 3-bit select register. Counting only advances in cycles where the oscillator reports that it is actually running. While the count advances, a thermometer-coded status register shows which of the selectable intervals have already elapsed.

If a deep-sleep command arrives while an unmasked interrupt is already pending, the block never switches the oscillator off. It still holds the CPU clock closed for the full selected interval.

Top module: `stby_ctrl`

## Requirements
- R1: An interrupt whose request bit is 1 and whose mask bit is 0 wakes the block. A request whose mask bit is 1 does not. From light sleep, a wake returns to RUN. From deep sleep, a wake moves to the settling state and raises `osc_en` on the next cycle.
- R2: If `stop_req` arrives in RUN while an unmasked request is pending, the block goes straight to the settling state. `osc_en` stays 1 and `cpu_clk_en` stays 0 until the full selected interval has been counted.
- R3: Status bit k sets once the settling count reaches interval k, but only for k not above the current select value. Bits above the select value are never set by that count.
- R4: The settling count advances only in cycles where `osc_run` is 1. Cycles with `osc_run` at 0 do not shorten the wait.
- R5: A write to the select register takes effect on the next cycle only in RUN or light sleep. Writes in deep sleep or during settling are ignored.
- R6: Synchronous reset puts the block in RUN, clears the status to 0 and loads the select register with all ones. This holds even when reset is applied during deep sleep.
- R7: While `rst` is 1, `osc_en` and `cpu_clk_en` are both 0 in the same cycle.
- R8: Select value k means a wait of 2^e `osc_run` cycles, where e = max(BASE_EXP + STEP_EXP*k, MIN_EXP). The block returns to RUN on the clock edge that samples the last counted cycle.
- R9: The status register reads 0 in the cycle after a `stop_req` is accepted in RUN.
- R10: `halt_req` in RUN closes `cpu_clk_en` and keeps `osc_en` at 1. A wake in light sleep reopens `cpu_clk_en` on the next cycle, with no settling wait.
- R11: `cpu_clk_en` is 1 only in RUN. `osc_en` is 0 only in deep sleep or reset.
- R12: When `stop_req` and `halt_req` arrive together in RUN, deep sleep wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Deep sleep command strobe |
| halt_req | input | 1 | Light sleep command strobe |
| irq_req | input | NUM_IRQ | Interrupt request flags |
| irq_mask | input | NUM_IRQ | Interrupt mask flags, 1 = masked |
| sel_we | input | 1 | Select register write strobe |
| sel_wdata | input | SEL_W | Select register write data |
| sel_q | output | SEL_W | Current select value |
| osc_run | input | 1 | Oscillator running indication |
| osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| stab_status | output | 2**SEL_W | Thermometer settling status |

## Verification
The bench builds the block with 4 interrupt lines, BASE_EXP=2, STEP_EXP=1 and MIN_EXP=3. With these values every interval is between 8 and 512 cycles, so complete settling runs fit in a short test. Because MIN_EXP is above BASE_EXP, the floor clamp is active: select values 0 and 1 share the same length. This lets the bench see the saturation rule set exactly the bits allowed by the select value and no others. A gap in `osc_run` placed in the middle of a count shows whether the wait length counts only running cycles.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_STOP = 2'd2,
        ST_WAIT = 2'd3
    } stby_state_e;

    // exponent of the settling wait for select code k, never below the floor
    function automatic int unsigned wait_exp(input int unsigned k,
                                             input int unsigned base_e,
                                             input int unsigned step_e,
                                             input int unsigned floor_e);
        int unsigned e;
        e = base_e + step_e * k;
        return (e < floor_e) ? floor_e : e;
    endfunction

endpackage

// File: rtl/stby_wake.sv
module stby_wake #(
    parameter int unsigned NUM_IRQ = 8
) (
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_mask,
    output logic               wake
);
    logic [NUM_IRQ-1:0] live;

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_live
        assign live[g] = irq_req[g] & ~irq_mask[g];
    end

    assign wake = |live;
endmodule

// File: rtl/stby_sel_reg.sv
module stby_sel_reg #(
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             allow,
    input  logic [SEL_W-1:0] wdata,
    output logic [SEL_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '1;
        end else if (we && allow) begin
            q <= wdata;
        end
    end
endmodule

// File: rtl/stby_stab_counter.sv
module stby_stab_counter
    import stby_pkg::*;
#(
    parameter int unsigned SEL_W    = 3,
    parameter int unsigned BASE_EXP = 8,
    parameter int unsigned STEP_EXP = 2,
    parameter int unsigned MIN_EXP  = 8,
    parameter int unsigned CNT_W    = 24
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear,
    input  logic                  count_en,
    input  logic [SEL_W-1:0]      sel,
    output logic [(1<<SEL_W)-1:0] status,
    output logic                  done
);
    localparam int unsigned NSEL = 1 << SEL_W;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nx;
    logic [CNT_W-1:0] len_k [NSEL];
    logic [NSEL-1:0]  reach;

    assign cnt_nx = cnt + 1'b1;

    for (genvar g = 0; g < NSEL; g++) begin : g_len
        assign len_k[g] = {{(CNT_W-1){1'b0}}, 1'b1} << wait_exp(g, BASE_EXP, STEP_EXP, MIN_EXP);
        assign reach[g] = (cnt_nx >= len_k[g]) && (SEL_W'(g) <= sel);

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                status[g] <= 1'b0;
            end else if (count_en && reach[g]) begin
                status[g] <= 1'b1;
            end
        end
    end

    assign done = count_en && (cnt_nx == len_k[sel]);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (count_en) begin
            cnt <= cnt_nx;
        end
    end
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
    import stby_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        stop_req,
    input  logic        halt_req,
    input  logic        wake,
    input  logic        done,
    output stby_state_e state,
    output logic        clr_stab
);
    stby_state_e state_nx;

    always_comb begin
        state_nx = state;
        clr_stab = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (stop_req) begin
                    clr_stab = 1'b1;
                    state_nx = wake ? ST_WAIT : ST_STOP;
                end else if (halt_req) begin
                    state_nx = ST_HALT;
                end
            end
            ST_HALT: if (wake) state_nx = ST_RUN;
            ST_STOP: begin
                if (wake) begin
                    clr_stab = 1'b1;
                    state_nx = ST_WAIT;
                end
            end
            ST_WAIT: if (done) state_nx = ST_RUN;
            default: state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= state_nx;
    end
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
    import stby_pkg::*;
#(
    parameter int unsigned NUM_IRQ  = 8,
    parameter int unsigned SEL_W    = 3,
    parameter int unsigned BASE_EXP = 8,
    parameter int unsigned STEP_EXP = 2,
    parameter int unsigned MIN_EXP  = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  stop_req,
    input  logic                  halt_req,
    input  logic [NUM_IRQ-1:0]    irq_req,
    input  logic [NUM_IRQ-1:0]    irq_mask,
    input  logic                  sel_we,
    input  logic [SEL_W-1:0]      sel_wdata,
    output logic [SEL_W-1:0]      sel_q,
    input  logic                  osc_run,
    output logic                  osc_en,
    output logic                  cpu_clk_en,
    output logic [(1<<SEL_W)-1:0] stab_status
);
    localparam int unsigned NSEL    = 1 << SEL_W;
    localparam int unsigned TOP_EXP = wait_exp(NSEL - 1, BASE_EXP, STEP_EXP, MIN_EXP);
    localparam int unsigned CNT_W   = TOP_EXP + 1;

    stby_state_e state_q;
    logic        wake;
    logic        done;
    logic        clr_stab;
    logic        count_en;
    logic        sel_allow;

    stby_wake #(.NUM_IRQ(NUM_IRQ)) u_wake (
        .irq_req (irq_req),
        .irq_mask(irq_mask),
        .wake    (wake)
    );

    stby_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .stop_req(stop_req),
        .halt_req(halt_req),
        .wake    (wake),
        .done    (done),
        .state   (state_q),
        .clr_stab(clr_stab)
    );

    assign sel_allow = (state_q == ST_RUN) || (state_q == ST_HALT);

    stby_sel_reg #(.SEL_W(SEL_W)) u_sel (
        .clk  (clk),
        .rst  (rst),
        .we   (sel_we),
        .allow(sel_allow),
        .wdata(sel_wdata),
        .q    (sel_q)
    );

    assign count_en = (state_q == ST_WAIT) && osc_run;

    stby_stab_counter #(
        .SEL_W   (SEL_W),
        .BASE_EXP(BASE_EXP),
        .STEP_EXP(STEP_EXP),
        .MIN_EXP (MIN_EXP),
        .CNT_W   (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clear   (clr_stab),
        .count_en(count_en),
        .sel     (sel_q),
        .status  (stab_status),
        .done    (done)
    );

    assign osc_en     = !rst && (state_q != ST_STOP);
    assign cpu_clk_en = !rst && (state_q == ST_RUN);
endmodule

// File: rtl/stby_ctrl_chk.sv
module stby_ctrl_chk
    import stby_pkg::*;
#(
    parameter int unsigned SEL_W = 3
) (
    input logic                  clk,
    input logic                  rst,
    input stby_state_e           state,
    input logic                  stop_req,
    input logic                  wake,
    input logic                  osc_run,
    input logic                  osc_en,
    input logic                  cpu_clk_en,
    input logic [SEL_W-1:0]      sel_q,
    input logic [(1<<SEL_W)-1:0] stab_status
);
    localparam int unsigned NSEL = 1 << SEL_W;

    logic [NSEL-1:0] allowed;
    for (genvar g = 0; g < NSEL; g++) begin : g_allowed
        assign allowed[g] = (SEL_W'(g) <= sel_q);
    end

    always_comb begin
        if (rst) begin
            p_gates_low_r7: assert (!osc_en && !cpu_clk_en)
                else $error("outputs active during reset");
        end
    end

    p_cpu_needs_osc_r11: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_en |-> osc_en);

    p_status_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |-> ((stab_status & ~allowed) == '0));

    p_sel_locked_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOP || state == ST_WAIT) |=> $stable(sel_q));

    p_halt_wake_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT && wake) |=> cpu_clk_en);

    p_stop_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && stop_req) |=> (stab_status == '0));

    p_osc_gated_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && !osc_run) |=> (state == ST_WAIT && $stable(stab_status)));
endmodule

bind stby_ctrl stby_ctrl_chk #(.SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .state      (state_q),
    .stop_req   (stop_req),
    .wake       (wake),
    .osc_run    (osc_run),
    .osc_en     (osc_en),
    .cpu_clk_en (cpu_clk_en),
    .sel_q      (sel_q),
    .stab_status(stab_status)
);

// File: tb/test_stby_ctrl.sv
module test_stby_ctrl;
    localparam int unsigned NUM_IRQ  = 4;
    localparam int unsigned SEL_W    = 3;
    localparam int unsigned BASE_EXP = 2;
    localparam int unsigned STEP_EXP = 1;
    localparam int unsigned MIN_EXP  = 3;
    localparam int unsigned NSEL     = 1 << SEL_W;

    typedef struct {
        logic             osc;
        logic             cpu;
        logic [NSEL-1:0]  stat;
        logic [SEL_W-1:0] sel;
        string            tag;
    } exp_t;

    logic                  clk = 1'b0;
    logic                  rst;
    logic                  stop_req, halt_req, sel_we, osc_run;
    logic [NUM_IRQ-1:0]    irq_req, irq_mask;
    logic [SEL_W-1:0]      sel_wdata, sel_q;
    logic                  osc_en, cpu_clk_en;
    logic [NSEL-1:0]       stab_status;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   finished = 0;

    always #5 clk = ~clk;

    stby_ctrl #(
        .NUM_IRQ(NUM_IRQ), .SEL_W(SEL_W), .BASE_EXP(BASE_EXP),
        .STEP_EXP(STEP_EXP), .MIN_EXP(MIN_EXP)
    ) i_stby_ctrl (
        .clk(clk), .rst(rst), .stop_req(stop_req), .halt_req(halt_req),
        .irq_req(irq_req), .irq_mask(irq_mask), .sel_we(sel_we),
        .sel_wdata(sel_wdata), .sel_q(sel_q), .osc_run(osc_run),
        .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .stab_status(stab_status)
    );

    // wait length for a select code, from the requirement R8
    function automatic int unsigned exp_len(input int unsigned k);
        int unsigned e;
        e = BASE_EXP + STEP_EXP * k;
        if (e < MIN_EXP) e = MIN_EXP;
        return 1 << e;
    endfunction

    // status after n counted cycles with select s (R3)
    function automatic logic [NSEL-1:0] exp_stat(input int unsigned n, input int unsigned s);
        logic [NSEL-1:0] r;
        r = '0;
        for (int k = 0; k < NSEL; k++) begin
            if (k <= s && n >= exp_len(k)) r[k] = 1'b1;
        end
        return r;
    endfunction

    // driver: push expected outputs after the coming edge, then advance
    task automatic tick(input logic eo, input logic ec, input logic [NSEL-1:0] es,
                        input logic [SEL_W-1:0] esel, input string tag);
        exp_t it;
        it.osc = eo; it.cpu = ec; it.stat = es; it.sel = esel; it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
    endtask

    // count a full settling run with select s; one osc_run gap after 4 cycles
    task automatic settle(input int unsigned s, input string tag);
        int unsigned n;
        n = 0;
        osc_run = 1'b1;
        while (n < exp_len(s)) begin
            if (n == 4) begin
                osc_run = 1'b0;
                sel_we = 1'b1; sel_wdata = SEL_W'(s + 2);
                tick(1'b1, 1'b0, exp_stat(n, s), SEL_W'(s), "R4/R5 gap, write ignored in settling");
                sel_we = 1'b0;
                osc_run = 1'b1;
            end
            n++;
            if (n == exp_len(s))
                tick(1'b1, 1'b1, exp_stat(n, s), SEL_W'(s), tag);
            else
                tick(1'b1, 1'b0, exp_stat(n, s), SEL_W'(s), "R3/R8 settling in progress");
        end
    endtask

    // monitor: compare outputs shortly after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t it;
                it = exp_q.pop_front();
                checks++;
                if (osc_en !== it.osc || cpu_clk_en !== it.cpu ||
                    stab_status !== it.stat || sel_q !== it.sel) begin
                    fails++;
                    $display("FAIL %s: got osc=%b cpu=%b stat=%h sel=%0d, expected osc=%b cpu=%b stat=%h sel=%0d",
                             it.tag, osc_en, cpu_clk_en, stab_status, sel_q,
                             it.osc, it.cpu, it.stat, it.sel);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; stop_req = 1'b0; halt_req = 1'b0; sel_we = 1'b0;
        sel_wdata = '0; osc_run = 1'b0; irq_req = '0; irq_mask = '1;
        tick(1'b0, 1'b0, '0, '1, "R7 gates low in reset");
        tick(1'b0, 1'b0, '0, '1, "R6 reset values");
        rst = 1'b0;
        tick(1'b1, 1'b1, '0, '1, "R11 run after reset");
        sel_we = 1'b1; sel_wdata = 3'd1;
        tick(1'b1, 1'b1, '0, 3'd1, "R5 write accepted in RUN");
        sel_we = 1'b0;
        // light sleep
        halt_req = 1'b1;
        tick(1'b1, 1'b0, '0, 3'd1, "R10 halt keeps oscillator");
        halt_req = 1'b0;
        irq_req = 4'b0001; irq_mask = 4'b0001;
        tick(1'b1, 1'b0, '0, 3'd1, "R1 masked request no wake");
        tick(1'b1, 1'b0, '0, 3'd1, "R1 masked request no wake");
        irq_mask = 4'b0000;
        tick(1'b1, 1'b1, '0, 3'd1, "R10 wake to RUN next cycle");
        irq_req = '0; irq_mask = '1;
        // deep sleep, stop wins over halt
        stop_req = 1'b1; halt_req = 1'b1;
        tick(1'b0, 1'b0, '0, 3'd1, "R12 stop over halt");
        stop_req = 1'b0; halt_req = 1'b0;
        sel_we = 1'b1; sel_wdata = 3'd5;
        tick(1'b0, 1'b0, '0, 3'd1, "R5 write ignored in STOP");
        sel_we = 1'b0;
        irq_req = 4'b0010; irq_mask = 4'b0010;
        tick(1'b0, 1'b0, '0, 3'd1, "R1 masked request stays in STOP");
        irq_mask = 4'b0000;
        tick(1'b1, 1'b0, '0, 3'd1, "R1 wake from STOP starts oscillator");
        irq_req = '0; irq_mask = '1;
        for (int i = 0; i < 3; i++)
            tick(1'b1, 1'b0, '0, 3'd1, "R4 no count while oscillator idle");
        settle(1, "R8 select 1 wait complete");
        sel_we = 1'b1; sel_wdata = 3'd0;
        tick(1'b1, 1'b1, exp_stat(exp_len(1), 1), 3'd0, "R5 write select 0");
        sel_we = 1'b0;
        // stop with pending unmasked interrupt
        irq_req = 4'b0100; irq_mask = 4'b0000; stop_req = 1'b1;
        tick(1'b1, 1'b0, '0, 3'd0, "R2 pending goes to settling, R9 clear");
        stop_req = 1'b0; irq_req = '0; irq_mask = '1;
        settle(0, "R2 full wait then RUN, R3 only bit 0, R8 floor");
        // thermometer with select 2
        sel_we = 1'b1; sel_wdata = 3'd2;
        tick(1'b1, 1'b1, exp_stat(exp_len(0), 0), 3'd2, "R5 write select 2");
        sel_we = 1'b0; osc_run = 1'b0;
        stop_req = 1'b1;
        tick(1'b0, 1'b0, '0, 3'd2, "R9 status cleared on STOP");
        stop_req = 1'b0;
        irq_req = 4'b1000; irq_mask = 4'b0000;
        tick(1'b1, 1'b0, '0, 3'd2, "R1 wake from STOP");
        irq_req = '0; irq_mask = '1;
        settle(2, "R3 thermometer bits 0..2 at end");
        // reset during deep sleep
        stop_req = 1'b1;
        tick(1'b0, 1'b0, '0, 3'd2, "R11 oscillator off in STOP");
        stop_req = 1'b0; rst = 1'b1;
        tick(1'b0, 1'b0, '0, '1, "R6 reset from STOP");
        rst = 1'b0;
        tick(1'b1, 1'b1, '0, '1, "R6 RUN after reset from STOP");
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule